// File: doc/BRIEF.md
# Bridge Power Sequencer with Ready Polling

This block sequences the power pins of an external bridge device. A request pulse in the off state starts the power-up. The rails are enabled first, then power-down is released while reset stays asserted. Reset is released after a fixed hold, and a fixed settle delay follows. The block then samples a ready indication from the device at a fixed interval. It stops sampling when the indication is high at a sample, or when a bounded number of samples has passed. In the second case the block flags a timeout and keeps the device powered.

Once powered, the device stays up until no request has arrived for an idle window. Each request inside the window restarts the window. When the window expires, the block asserts reset, then power-down, then turns the rails off, one step per cycle. A request that arrives during that shutdown is held. It starts a full power-up as soon as the rails are off. All durations are given in milliseconds and scaled by a clock-cycles-per-millisecond parameter.

Top module: `bridge_pwr_seq`

## Requirements
- R1: While rst_ni is low and after its release with no request, rail_en_o=0, pwrdn_o=1, reset_o=1, and busy_o, ready_o and timeout_o are 0.
- R2: A request sampled in the off state sets rail_en_o the next cycle with pwrdn_o and reset_o still 1. One cycle later pwrdn_o drops while reset_o stays 1.
- R3: reset_o is released exactly RST_HOLD_MS*CLK_PER_MS cycles after pwrdn_o is released.
- R4: After reset_o is released, no ready sample is taken for SETTLE_MS*CLK_PER_MS cycles. The first sample is taken in the cycle after that.
- R5: hpd_i is sampled once every POLL_MS*CLK_PER_MS cycles. ready_o rises in the cycle after the first sample that sees hpd_i high. A rise of hpd_i between samples waits for the next sample.
- R6: If hpd_i is low at all HPD_TMO_MS/POLL_MS+1 samples, timeout_o rises after the last sample. When that happens, rail_en_o=1, pwrdn_o=0 and reset_o=0, and the device stays powered.
- R7: Power is held for IDLE_MS*CLK_PER_MS cycles after ready_o or timeout_o rises. Power-down then runs one step per cycle: first reset_o=1, then pwrdn_o=1, then rail_en_o=0.
- R8: A request while powered restarts the idle count from that cycle. The power-up is not re-run, and reset_o stays 0.
- R9: A request during the power-down steps is held. After one cycle with the rails off, a full power-up begins without a new request.
- R10: busy_o is 1 in every state except off and powered.
- R11: ready_o and timeout_o are never both 1, and both drop on the first power-down step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Access request, one pulse per access |
| hpd_i | input | 1 | Ready indication from the device |
| rail_en_o | output | 1 | Supply rail enable |
| pwrdn_o | output | 1 | Device power-down, active high |
| reset_o | output | 1 | Device reset, active high |
| ready_o | output | 1 | Powered, and ready was seen |
| timeout_o | output | 1 | Powered, and ready was not seen in time |
| busy_o | output | 1 | Sequencing in progress |

## Verification
The bench sweeps the sample at which the ready input first reads high, across every sample slot and the no-ready case. For each run it predicts every output in every cycle from the parameter arithmetic. An off-by-one in any timer shows up as a reset pulse, settle delay, poll interval or idle window that is one cycle short or long, so outputs change one cycle early or late. If hpd_i were sampled continuously instead of at the poll ticks, ready would rise early. Further runs send a request inside the idle window, and another during power-down. A design that did not restart the window would power down early. One that dropped the late request would stay off.

// File: rtl/bps_pkg.sv
package bps_pkg;
  typedef enum logic [2:0] {
    ST_OFF,
    ST_RAIL,
    ST_PDREL,
    ST_SETTLE,
    ST_POLL,
    ST_ON,
    ST_DN_RST,
    ST_DN_PD
  } seq_state_e;
endpackage

// File: rtl/bps_down_cnt.sv
module bps_down_cnt #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic         done_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (load_i)         cnt_q <= val_i;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign done_o = (cnt_q == '0);
endmodule

// File: rtl/bps_poll_unit.sv
module bps_poll_unit #(
  parameter int unsigned POLL_CYC = 8,
  parameter int unsigned NSAMP    = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic active_i,
  output logic smp_o,
  output logic last_o
);
  localparam int unsigned PW = (POLL_CYC > 1) ? $clog2(POLL_CYC) : 1;
  localparam int unsigned IW = $clog2(NSAMP + 1);
  localparam logic [PW-1:0] POLL_LD = PW'(POLL_CYC - 1);
  localparam logic [IW-1:0] LAST_IDX = IW'(NSAMP - 1);

  logic          tick;
  logic          ld;
  logic [PW-1:0] ld_val;
  logic [IW-1:0] idx_q;

  // first sample right at entry, then one per interval
  assign ld     = start_i || smp_o;
  assign ld_val = start_i ? '0 : POLL_LD;
  assign smp_o  = active_i && tick;
  assign last_o = (idx_q == LAST_IDX);

  bps_down_cnt #(.W(PW)) u_tick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (ld),
    .val_i  (ld_val),
    .done_o (tick)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     idx_q <= '0;
    else if (start_i)                idx_q <= '0;
    else if (smp_o && !last_o)       idx_q <= idx_q + 1'b1;
  end
endmodule

// File: rtl/bridge_pwr_seq.sv
module bridge_pwr_seq
  import bps_pkg::*;
#(
  parameter int unsigned CLK_PER_MS  = 100000,
  parameter int unsigned RST_HOLD_MS = 2,
  parameter int unsigned SETTLE_MS   = 200,
  parameter int unsigned POLL_MS     = 20,
  parameter int unsigned HPD_TMO_MS  = 200,
  parameter int unsigned IDLE_MS     = 500
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  input  logic hpd_i,
  output logic rail_en_o,
  output logic pwrdn_o,
  output logic reset_o,
  output logic ready_o,
  output logic timeout_o,
  output logic busy_o
);
  localparam int unsigned RST_CYC  = RST_HOLD_MS * CLK_PER_MS;
  localparam int unsigned SET_CYC  = SETTLE_MS * CLK_PER_MS;
  localparam int unsigned POLL_CYC = POLL_MS * CLK_PER_MS;
  localparam int unsigned IDLE_CYC = IDLE_MS * CLK_PER_MS;
  localparam int unsigned NSAMP    = HPD_TMO_MS / POLL_MS + 1;
  localparam int unsigned MAX_A    = (RST_CYC > SET_CYC) ? RST_CYC : SET_CYC;
  localparam int unsigned MAX_CYC  = (MAX_A > IDLE_CYC) ? MAX_A : IDLE_CYC;
  localparam int unsigned CW       = $clog2(MAX_CYC + 1);
  localparam logic [CW-1:0] RST_LD  = CW'(RST_CYC - 1);
  localparam logic [CW-1:0] SET_LD  = CW'(SET_CYC - 1);
  localparam logic [CW-1:0] IDLE_LD = CW'(IDLE_CYC - 1);

  seq_state_e    state_q, state_d;
  logic          tmo_q, tmo_d;
  logic          pend_q;
  logic          step_ld;
  logic [CW-1:0] step_val;
  logic          step_done;
  logic          poll_start;
  logic          smp;
  logic          smp_last;

  bps_down_cnt #(.W(CW)) u_step (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (step_ld),
    .val_i  (step_val),
    .done_o (step_done)
  );

  bps_poll_unit #(.POLL_CYC(POLL_CYC), .NSAMP(NSAMP)) u_poll (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (poll_start),
    .active_i (state_q == ST_POLL),
    .smp_o    (smp),
    .last_o   (smp_last)
  );

  always_comb begin
    state_d    = state_q;
    tmo_d      = tmo_q;
    step_ld    = 1'b0;
    step_val   = '0;
    poll_start = 1'b0;
    unique case (state_q)
      ST_OFF:    if (req_i || pend_q) state_d = ST_RAIL;
      ST_RAIL: begin
        state_d  = ST_PDREL;
        step_ld  = 1'b1;
        step_val = RST_LD;
      end
      ST_PDREL: if (step_done) begin
        state_d  = ST_SETTLE;
        step_ld  = 1'b1;
        step_val = SET_LD;
      end
      ST_SETTLE: if (step_done) begin
        state_d    = ST_POLL;
        poll_start = 1'b1;
      end
      ST_POLL: if (smp && (hpd_i || smp_last)) begin
        state_d  = ST_ON;
        tmo_d    = !hpd_i;
        step_ld  = 1'b1;
        step_val = IDLE_LD;
      end
      ST_ON: begin
        if (req_i) begin
          step_ld  = 1'b1;
          step_val = IDLE_LD;
        end else if (step_done) begin
          state_d = ST_DN_RST;
        end
      end
      ST_DN_RST: state_d = ST_DN_PD;
      ST_DN_PD:  state_d = ST_OFF;
      default:   state_d = ST_OFF;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_OFF;
      tmo_q   <= 1'b0;
      pend_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      tmo_q   <= tmo_d;
      pend_q  <= (state_q == ST_DN_RST || state_q == ST_DN_PD) ? (pend_q || req_i) : 1'b0;
    end
  end

  assign rail_en_o = (state_q != ST_OFF);
  assign pwrdn_o   = (state_q == ST_OFF) || (state_q == ST_RAIL) || (state_q == ST_DN_PD);
  assign reset_o   = pwrdn_o || (state_q == ST_PDREL) || (state_q == ST_DN_RST);
  assign ready_o   = (state_q == ST_ON) && !tmo_q;
  assign timeout_o = (state_q == ST_ON) && tmo_q;
  assign busy_o    = (state_q != ST_OFF) && (state_q != ST_ON);

  // window counter for reset hold: pwrdn released, reset held
  logic [CW-1:0] rst_win_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                   rst_win_q <= '0;
    else if (rail_en_o && !pwrdn_o && reset_o) begin
      if (rst_win_q != '1)                         rst_win_q <= rst_win_q + 1'b1;
    end else                                       rst_win_q <= '0;
  end

  // R1
  rails_off_safe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rail_en_o |-> (pwrdn_o && reset_o));
  // R2
  pd_after_rail_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(pwrdn_o) |-> ($past(rail_en_o) && reset_o));
  // R3
  rst_hold_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(reset_o) |-> (!$past(pwrdn_o) && rst_win_q == CW'(RST_CYC)));
  // R5
  ready_needs_hpd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ready_o) |-> $past(hpd_i));
  // R6
  tmo_keeps_power_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(timeout_o) |-> (!$past(hpd_i) && rail_en_o && !pwrdn_o && !reset_o));
  // R7
  dn_pd_order_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pwrdn_o) && $past(rail_en_o) |-> (reset_o && rail_en_o && $past(reset_o)));
  // R7
  dn_rail_order_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(rail_en_o) |-> ($past(pwrdn_o) && $past(reset_o)));
  // R11
  flags_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ready_o && timeout_o));
  // R10
  busy_vs_flags_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !(ready_o || timeout_o));
endmodule

// File: tb/tb_bridge_pwr_seq.sv
module tb_bridge_pwr_seq;
  localparam int CLK_PERIOD = 10;
  localparam int CPM    = 4;
  localparam int RST_MS = 2;
  localparam int SET_MS = 5;
  localparam int POL_MS = 2;
  localparam int TMO_MS = 6;
  localparam int IDL_MS = 5;
  localparam int RST_C  = RST_MS * CPM;
  localparam int SET_C  = SET_MS * CPM;
  localparam int POLL_C = POL_MS * CPM;
  localparam int IDLE_C = IDL_MS * CPM;
  localparam int NS     = TMO_MS / POL_MS + 1;
  localparam int EP     = 1 + RST_C + SET_C;
  localparam int WDOG   = 100000;

  logic clk = 0;
  logic rst_n = 0;
  logic req = 0;
  logic hpd = 0;
  logic rail, pd, rs, rdy, tmo, busy;
  int   n_tests = 0;
  int   n_fail  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bridge_pwr_seq #(
    .CLK_PER_MS(CPM), .RST_HOLD_MS(RST_MS), .SETTLE_MS(SET_MS),
    .POLL_MS(POL_MS), .HPD_TMO_MS(TMO_MS), .IDLE_MS(IDL_MS)
  ) dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .hpd_i(hpd),
    .rail_en_o(rail), .pwrdn_o(pd), .reset_o(rs),
    .ready_o(rdy), .timeout_o(tmo), .busy_o(busy)
  );

  task automatic chk(input string tag, input logic [4:0] act, input logic [4:0] exp, input int k);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s k=%0d {rail,pd,rst,rdy,tmo} actual=%b expected=%b", tag, k, act, exp);
    end
  endtask

  task automatic chk_busy(input logic act, input logic exp, input int k);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL R10 k=%0d busy actual=%b expected=%b", k, act, exp);
    end
  endtask

  // j: sample index at which hpd first reads high (NS = never)
  // roff: >=0 sends a request roff cycles into the powered window
  task automatic run(input int j, input bit started, input int roff, input bit pend_req);
    int eon, edn;
    string tag;
    logic [4:0] e;
    logic eb;
    eon = (j < NS) ? EP + j * POLL_C + 1 : EP + (NS - 1) * POLL_C + 1;
    edn = (roff >= 0) ? eon + roff + 1 + IDLE_C : eon + IDLE_C;
    if (j == 0) hpd = 1;
    if (!started) req = 1;
    for (int k = 0; k <= edn + 2; k++) begin
      @(posedge clk);
      @(negedge clk);
      if (k == 0) req = 0;
      eb = 1'b1;
      if (k == 0) begin
        e = 5'b11100; tag = started ? "R9" : "R2";
      end else if (k == 1) begin
        e = 5'b10100; tag = "R2";
      end else if (k <= RST_C) begin
        e = 5'b10100; tag = "R3";
      end else if (k < eon) begin
        e = 5'b10000; tag = (k <= EP) ? "R4" : "R5";
      end else if (k < edn) begin
        e = (j < NS) ? 5'b10010 : 5'b10001; eb = 1'b0;
        tag = (j == NS) ? "R6" : ((roff >= 0) ? "R8" : "R5");
      end else if (k == edn) begin
        e = 5'b10100; tag = "R11";
      end else if (k == edn + 1) begin
        e = 5'b11100; tag = "R7";
      end else begin
        e = 5'b01100; eb = 1'b0; tag = "R7";
      end
      chk(tag, {rail, pd, rs, rdy, tmo}, e, k);
      chk_busy(busy, eb, k);
      if (j > 0 && j < NS && k == EP + (j - 1) * POLL_C + 1) hpd = 1;
      if (roff >= 0 && k == eon + roff) req = 1;
      if (roff >= 0 && k == eon + roff + 1) req = 0;
      if (pend_req && k == edn) req = 1;
      if (pend_req && k == edn + 1) req = 0;
    end
    hpd = 0;
  endtask

  initial begin
    repeat (WDOG) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: during reset
    chk("R1", {rail, pd, rs, rdy, tmo}, 5'b01100, -1);
    chk_busy(busy, 1'b0, -1);
    rst_n = 1;
    repeat (4) @(negedge clk);
    // R1: after release, no request
    chk("R1", {rail, pd, rs, rdy, tmo}, 5'b01100, -1);
    chk_busy(busy, 1'b0, -1);
    // sweep ready slot with and without an in-window request
    for (int j = 0; j <= NS; j++) begin
      run(j, 1'b0, -1, 1'b0);
      run(j, 1'b0, 3, 1'b0);
    end
    // request late in the window (R8)
    run(1, 1'b0, IDLE_C - 2, 1'b0);
    // request during power-down, then the resulting power-up (R9)
    run(2, 1'b0, -1, 1'b1);
    run(0, 1'b1, -1, 1'b0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule